// File: doc/BRIEF.md
# Multi-stage handshake clock-crossing pipeline

This block moves data words from a sender clock domain into an unrelated receiver clock domain through a chain of storage stages. Adjacent stages talk with a single-rail two-phase handshake. A request wire flips once for every word offered. The acknowledge wire flips back once the word has been taken. No wire returns to zero between words.

Every stage registers its request and acknowledge inputs before it acts on them. It only copies the word from its upstream neighbour after the registered request shows a new phase, so the data has been stable for at least one whole sampling interval by then. Stages alternate between the rising and falling clock edge. The crossing is therefore resolved a little at each hop, with roughly half a period of settling time per stage, and not in one two-flop step at the end. The last three stages run on the receiver clock. The ones before them run on the sender clock, so the backward acknowledge is resolved into the sender clock by the same kind of alternating chain.

A plain valid/ready port on each side connects the chain to its users. The sender port holds one word in flight. The receiver port presents the word held by the last stage.

Top module: `pipe_sync_bridge`

## Requirements
- R1: After reset, `snd_ready` is 1 and `rcv_valid` is 0, and every request and acknowledge phase is 0, so all stages are empty.
- R2: Words leave on the receiver side in the order they were accepted on the sender side, with none lost and none repeated. A stage raises a new request only while it is empty, which means its request phase equals the acknowledge phase returned by the next stage.
- R3: In the sender clock cycle right after a word is accepted (`snd_valid` and `snd_ready` both 1 at a rising `snd_clk` edge), `snd_ready` is 0.
- R4: While `rcv_valid` is 1 and `rcv_ready` is 0, `rcv_valid` stays 1 and `rcv_data` stays unchanged on the next rising `rcv_clk` edge.
- R5: A stage keeps its data register unchanged for as long as its outgoing request is still unacknowledged.
- R6: If the receiver never takes a word, the block accepts exactly NUM_STAGES+1 words: one in each stage and one at the sender port. After that `snd_ready` stays 0, and `rcv_data` shows the first word accepted.
- R7: A toggle of the request in either direction signals a word. A second word, whose request returns the wires to level 0, is delivered the same way as the first.
- R8: Once every accepted word has been taken and the pipeline has settled, `snd_ready` is 1 and `rcv_valid` is 0 again.
- R9: Asserting both resets while words are in flight discards those words. Afterwards the block behaves as after R1, and the next word sent is the next word received.
- R10: The first NUM_STAGES-3 stages are clocked by `snd_clk` and the last three by `rcv_clk`. Within each domain the edges alternate, starting with the rising edge, so the last stage is rising-edge clocked. `rcv_valid` and `rcv_data` change only on rising `rcv_clk` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| snd_clk | input | 1 | Sender domain clock |
| snd_rst_n | input | 1 | Sender domain reset, asynchronous assert, active low |
| snd_valid | input | 1 | Sender offers a word |
| snd_ready | output | 1 | Sender port can take a word |
| snd_data | input | DATA_W | Word offered by the sender |
| rcv_clk | input | 1 | Receiver domain clock |
| rcv_rst_n | input | 1 | Receiver domain reset, asynchronous assert, active low |
| rcv_valid | output | 1 | A word is presented to the receiver |
| rcv_ready | input | 1 | Receiver takes the presented word |
| rcv_data | output | DATA_W | Word presented to the receiver |

## Verification
The bench runs the two domains with unrelated clock periods and tries several traffic patterns:
- Free flow on both sides shows whether words pass from stage to stage without duplication when the chain is kept busy.
- A sparse sender exposes stages that fail to go empty between words.
- A heavily stalled receiver drives backpressure through every acknowledge hop, and the receiver hold rule is checked while the receiver is stalled.
- Random stalls on both sides mix the request phases in every stage.

Directed runs cover the single-word case, the two request polarities, the exact fill depth with the receiver blocked, and a reset taken while the chain is full.

// File: rtl/pipe_sync_pkg.sv
`timescale 1ns/1ps
package pipe_sync_pkg;

  // Stages in the receiving domain; the mirror chain for the acknowledge
  // sits in the sending domain just ahead of them.
  localparam int RCV_SYNC_STAGES = 3;

  // Edge choice per stage: alternate within each domain, starting rising.
  function automatic bit on_fall(input int idx, input int n_snd);
    if (idx < n_snd) return bit'(idx % 2);
    return bit'((idx - n_snd) % 2);
  endfunction

endpackage

// File: rtl/psb_send_port.sv
`timescale 1ns/1ps
module psb_send_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              ack_i
);

  logic              req_q;
  logic [DATA_W-1:0] data_q;
  logic              fire;
  logic              req_d;

  // The port is free once the first stage has echoed our request phase.
  always_comb begin
    ready_o = (req_q == ack_i);
    fire    = valid_i && ready_o;
    req_d   = fire ? ~req_q : req_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      req_q <= req_d;
      if (fire) data_q <= data_i;
    end
  end

  assign req_o  = req_q;
  assign data_o = data_q;

  AST_SND_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o)
    else $error("sender port ready again right after a transfer"); // R3

endmodule

// File: rtl/psb_stage.sv
`timescale 1ns/1ps
module psb_stage #(
  parameter int DATA_W    = 16,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              ack_i
);

  // Sampled views of the neighbours' phase wires.
  logic              req_smp_q;
  logic              ack_smp_q;
  // Own phases and payload.
  logic              ack_q;
  logic              req_q;
  logic [DATA_W-1:0] data_q;

  logic pending;
  logic vacant;
  logic take;
  logic ack_d;
  logic req_d;

  always_comb begin
    pending = (req_smp_q != ack_q);   // upstream flipped: new word waiting
    vacant  = (req_q == ack_smp_q);   // downstream echoed: our slot is free
    take    = pending && vacant;
    ack_d   = take ? req_smp_q : ack_q;
    req_d   = take ? ~req_q    : req_q;
  end

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          req_smp_q <= 1'b0;
          ack_smp_q <= 1'b0;
          ack_q     <= 1'b0;
          req_q     <= 1'b0;
          data_q    <= '0;
        end else begin
          req_smp_q <= req_i;
          ack_smp_q <= ack_i;
          ack_q     <= ack_d;
          req_q     <= req_d;
          if (take) data_q <= data_i;
        end
      end

      AST_STAGE_HOLD: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (req_q != ack_smp_q) |=> $stable(data_q))
        else $error("stage payload moved while occupied"); // R5
      AST_STAGE_NO_REISSUE: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (req_q != ack_smp_q) |=> $stable(req_q))
        else $error("stage requested again while occupied"); // R2
    end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          req_smp_q <= 1'b0;
          ack_smp_q <= 1'b0;
          ack_q     <= 1'b0;
          req_q     <= 1'b0;
          data_q    <= '0;
        end else begin
          req_smp_q <= req_i;
          ack_smp_q <= ack_i;
          ack_q     <= ack_d;
          req_q     <= req_d;
          if (take) data_q <= data_i;
        end
      end

      AST_STAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_q != ack_smp_q) |=> $stable(data_q))
        else $error("stage payload moved while occupied"); // R5
      AST_STAGE_NO_REISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_q != ack_smp_q) |=> $stable(req_q))
        else $error("stage requested again while occupied"); // R2
    end
  endgenerate

  assign ack_o  = ack_q;
  assign req_o  = req_q;
  assign data_o = data_q;

endmodule

// File: rtl/psb_recv_port.sv
`timescale 1ns/1ps
module psb_recv_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o
);

  logic ack_q;
  logic ack_d;

  always_comb begin
    valid_o = (req_i != ack_q);
    ack_d   = (valid_o && ready_i) ? ~ack_q : ack_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_d;
  end

  assign ack_o  = ack_q;
  assign data_o = data_i;

  AST_RCV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)))
    else $error("receiver word dropped or changed while stalled"); // R4

endmodule

// File: rtl/pipe_sync_bridge.sv
`timescale 1ns/1ps
module pipe_sync_bridge #(
  parameter int DATA_W     = 16,
  parameter int NUM_STAGES = 6
) (
  input  logic              snd_clk,
  input  logic              snd_rst_n,
  input  logic              snd_valid,
  output logic              snd_ready,
  input  logic [DATA_W-1:0] snd_data,
  input  logic              rcv_clk,
  input  logic              rcv_rst_n,
  output logic              rcv_valid,
  input  logic              rcv_ready,
  output logic [DATA_W-1:0] rcv_data
);
  import pipe_sync_pkg::*;

  localparam int SND_STAGES = NUM_STAGES - RCV_SYNC_STAGES;

  // Link k joins stage k-1 to stage k; link 0 is the sender port,
  // link NUM_STAGES feeds the receiver port.
  logic              req_w  [0:NUM_STAGES];
  logic              ack_w  [0:NUM_STAGES];
  logic [DATA_W-1:0] data_w [0:NUM_STAGES];

  psb_send_port #(.DATA_W(DATA_W)) i_send (
    .clk_i   (snd_clk),
    .rst_ni  (snd_rst_n),
    .valid_i (snd_valid),
    .ready_o (snd_ready),
    .data_i  (snd_data),
    .req_o   (req_w[0]),
    .data_o  (data_w[0]),
    .ack_i   (ack_w[0])
  );

  generate
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      if (k < SND_STAGES) begin : g_snd
        psb_stage #(.DATA_W(DATA_W), .FALL_EDGE(on_fall(k, SND_STAGES))) i_stage (
          .clk_i  (snd_clk),
          .rst_ni (snd_rst_n),
          .req_i  (req_w[k]),
          .data_i (data_w[k]),
          .ack_o  (ack_w[k]),
          .req_o  (req_w[k+1]),
          .data_o (data_w[k+1]),
          .ack_i  (ack_w[k+1])
        );
      end else begin : g_rcv
        psb_stage #(.DATA_W(DATA_W), .FALL_EDGE(on_fall(k, SND_STAGES))) i_stage (
          .clk_i  (rcv_clk),
          .rst_ni (rcv_rst_n),
          .req_i  (req_w[k]),
          .data_i (data_w[k]),
          .ack_o  (ack_w[k]),
          .req_o  (req_w[k+1]),
          .data_o (data_w[k+1]),
          .ack_i  (ack_w[k+1])
        );
      end
    end
  endgenerate

  psb_recv_port #(.DATA_W(DATA_W)) i_recv (
    .clk_i   (rcv_clk),
    .rst_ni  (rcv_rst_n),
    .req_i   (req_w[NUM_STAGES]),
    .data_i  (data_w[NUM_STAGES]),
    .ack_o   (ack_w[NUM_STAGES]),
    .valid_o (rcv_valid),
    .ready_i (rcv_ready),
    .data_o  (rcv_data)
  );

  AST_EMPTY_AFTER_RESET: assert property (@(posedge rcv_clk) disable iff (!rcv_rst_n)
    $rose(rcv_rst_n) |-> !rcv_valid)
    else $error("receiver sees a word straight out of reset"); // R1

endmodule

// File: tb/test_pipe_sync_bridge.sv
`timescale 1ns/1ps
module test_pipe_sync_bridge;

  localparam int W      = 16;
  localparam int STAGES = 6;
  localparam int NPAT   = 6;
  // word count, sender stall percent, receiver stall percent
  localparam int PAT [NPAT][3] = '{
    '{40, 0, 0}, '{40, 70, 0}, '{40, 0, 70},
    '{40, 50, 50}, '{30, 10, 90}, '{1, 0, 0}
  };

  logic         snd_clk, rcv_clk, snd_rst_n, rcv_rst_n;
  logic         snd_valid, snd_ready, rcv_valid, rcv_ready;
  logic [W-1:0] snd_data, rcv_data;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  pipe_sync_bridge #(.DATA_W(W), .NUM_STAGES(STAGES)) i_pipe_sync_bridge (
    .snd_clk, .snd_rst_n, .snd_valid, .snd_ready, .snd_data,
    .rcv_clk, .rcv_rst_n, .rcv_valid, .rcv_ready, .rcv_data
  );

  initial snd_clk = 1'b0;
  always #2.5 snd_clk = ~snd_clk;
  initial rcv_clk = 1'b0;
  always #3.65 rcv_clk = ~rcv_clk;

  function automatic logic [W-1:0] word_of(input int p, input int i);
    return W'(p * 32'h1357) ^ W'(i * 32'h0a5b) ^ 16'h6c00;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    snd_rst_n = 1'b0; rcv_rst_n = 1'b0;
    snd_valid = 1'b0; rcv_ready = 1'b0;
    repeat (4) @(posedge snd_clk);
    @(posedge snd_clk); #1 snd_rst_n = 1'b1;
    @(posedge rcv_clk); #1 rcv_rst_n = 1'b1;
    repeat (3) @(posedge snd_clk);
  endtask

  task automatic send_seq(input int p, input int n, input int pct);
    int sidx = 0;
    bit fire;
    bit last_fire = 0;
    @(posedge snd_clk); #1;
    snd_valid = (int'($urandom_range(99)) >= pct);
    snd_data  = word_of(p, 0);
    while (sidx < n) begin
      @(negedge snd_clk);
      if (last_fire) check(!snd_ready, "R3 ready after transfer", 32'(snd_ready), 0);
      fire = snd_valid && snd_ready;
      last_fire = fire;
      @(posedge snd_clk); #1;
      if (fire) begin sidx++; snd_valid = 1'b0; end
      if (sidx < n && !snd_valid) begin
        snd_valid = (int'($urandom_range(99)) >= pct);
        snd_data  = word_of(p, sidx);
      end
    end
    snd_valid = 1'b0;
  endtask

  task automatic recv_seq(input int p, input int n, input int pct);
    int ridx = 0;
    bit held = 0;
    logic [W-1:0] hdat;
    logic snap_v;
    logic [W-1:0] snap_d;
    @(posedge rcv_clk); #1;
    rcv_ready = (int'($urandom_range(99)) >= pct);
    snap_v = rcv_valid; snap_d = rcv_data;
    while (ridx < n) begin
      @(negedge rcv_clk);
      check(rcv_valid == snap_v && rcv_data == snap_d, "R10 output moved off rising edge",
            {15'd0, rcv_valid, rcv_data}, {15'd0, snap_v, snap_d});
      if (held) check(rcv_valid && rcv_data == hdat, "R4 stalled word held",
                      {15'd0, rcv_valid, rcv_data}, {16'd1, hdat});
      held = rcv_valid && !rcv_ready;
      hdat = rcv_data;
      if (rcv_valid && rcv_ready) begin
        check(rcv_data == word_of(p, ridx), "R2 order", 32'(rcv_data), 32'(word_of(p, ridx)));
        ridx++;
      end
      @(posedge rcv_clk); #1;
      rcv_ready = (ridx < n) && (int'($urandom_range(99)) >= pct);
      snap_v = rcv_valid; snap_d = rcv_data;
    end
    rcv_ready = 1'b0;
  endtask

  task automatic send_one(input logic [W-1:0] w);
    bit done = 0;
    @(posedge snd_clk); #1;
    snd_valid = 1'b1; snd_data = w;
    while (!done) begin
      @(negedge snd_clk);
      done = snd_ready;
      @(posedge snd_clk); #1;
    end
    snd_valid = 1'b0;
    @(negedge snd_clk);
    check(!snd_ready, "R3 ready after single transfer", 32'(snd_ready), 0);
  endtask

  task automatic recv_one(input logic [W-1:0] w, input string tag);
    bit done = 0;
    @(posedge rcv_clk); #1 rcv_ready = 1'b1;
    while (!done) begin
      @(negedge rcv_clk);
      if (rcv_valid) begin
        check(rcv_data == w, tag, 32'(rcv_data), 32'(w));
        done = 1;
      end
      @(posedge rcv_clk); #1;
    end
    rcv_ready = 1'b0;
  endtask

  initial begin
    #900000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    bit fire;
    snd_data = '0;
    do_reset();
    @(negedge snd_clk);
    check(snd_ready, "R1 snd_ready after reset", 32'(snd_ready), 1);
    @(negedge rcv_clk);
    check(!rcv_valid, "R1 rcv_valid after reset", 32'(rcv_valid), 0);

    // Pattern table: each row one transfer with its own stall mix.
    for (int p = 0; p < NPAT; p++) begin
      fork
        send_seq(p, PAT[p][0], PAT[p][1]);
        recv_seq(p, PAT[p][0], PAT[p][2]);
      join
      repeat (40) @(posedge rcv_clk);
      @(negedge snd_clk);
      check(snd_ready, "R8 empty: snd_ready", 32'(snd_ready), 1);
      @(negedge rcv_clk);
      check(!rcv_valid, "R8 empty: rcv_valid", 32'(rcv_valid), 0);
    end

    // R7: two words, so the request wires go up and then back down.
    do_reset();
    send_one(word_of(7, 0));
    recv_one(word_of(7, 0), "R7 rising request");
    send_one(word_of(7, 1));
    recv_one(word_of(7, 1), "R7 falling request");

    // R6: fill with the receiver blocked.
    rcv_ready = 1'b0;
    cnt = 0;
    @(posedge snd_clk); #1;
    snd_valid = 1'b1; snd_data = word_of(9, 0);
    repeat (300) begin
      @(negedge snd_clk);
      fire = snd_valid && snd_ready;
      @(posedge snd_clk); #1;
      if (fire) begin cnt++; snd_data = word_of(9, cnt); end
    end
    snd_valid = 1'b0;
    check(cnt == STAGES + 1, "R6 fill depth", 32'(cnt), 32'(STAGES + 1));
    @(negedge snd_clk);
    check(!snd_ready, "R6 full: snd_ready", 32'(snd_ready), 0);
    @(negedge rcv_clk);
    check(rcv_valid && rcv_data == word_of(9, 0), "R6 first word presented",
          32'(rcv_data), 32'(word_of(9, 0)));
    recv_seq(9, STAGES + 1, 0);

    // R9: reset with words in flight.
    rcv_ready = 1'b0;
    @(posedge snd_clk); #1;
    snd_valid = 1'b1; snd_data = word_of(10, 0);
    repeat (30) @(posedge snd_clk);
    #1 snd_valid = 1'b0;
    do_reset();
    @(negedge snd_clk);
    check(snd_ready, "R9 snd_ready after reset", 32'(snd_ready), 1);
    @(negedge rcv_clk);
    check(!rcv_valid, "R9 rcv_valid after reset", 32'(rcv_valid), 0);
    send_one(word_of(11, 0));
    recv_one(word_of(11, 0), "R9 fresh word after reset");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule